// File: doc/BRIEF.md
# Two-Level Lookahead Adder

This block adds two 16-bit operands and a carry-in without any register. The operand is split into four 4-bit groups. Inside each group, every bit forms a propagate term (the bits differ) and a generate term (both bits set). Each carry of the group is computed straight from those terms in sum-of-products form, so no carry passes from one bit to the next. Each group also reports whether it would pass a carry through it (group propagate) and whether it creates a carry by itself (group generate). Neither flag depends on the carry-in.

A second lookahead unit takes the four pairs of group flags and the carry-in. It computes the carry into every group and the final carry-out. It also merges the four pairs into one block-level propagate/generate pair, so a wider adder can place this block under a third lookahead level. Because of the two levels, a late carry-in only selects between results that are already settled.

Top module: `cla_adder16`

## Requirements
- R1: `sum` equals the low 16 bits of `a + b + cin`.
- R2: `cout` equals bit 16 of the 17-bit result `a + b + cin`.
- R3: `blk_p` is 1 exactly when `a ^ b` is all ones, i.e. every bit position would pass a carry along.
- R4: `blk_g` is 1 exactly when `a + b` (carry-in taken as 0) is 65536 or more; its value does not change when `cin` toggles.
- R5: `blk_p` and `blk_g` are never 1 together.
- R6: `cout` always equals `blk_g | (blk_p & cin)`.
- R7: When `blk_p` and `blk_g` are both 0, `cout` is 0 for either value of `cin`.
- R8: Swapping `a` and `b` leaves `sum`, `cout`, `blk_p` and `blk_g` unchanged.
- R9: 16'hFFFF plus 16'h0001 with `cin` = 0 gives `sum` = 0 and `cout` = 1.
- R10: Adding 1 to a word that has exactly one 0 bit, at position k, gives bits below k cleared, bits k and above set, and `cout` = 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a | input | 16 | First operand |
| b | input | 16 | Second operand |
| cin | input | 1 | Carry into bit 0 |
| sum | output | 16 | Sum bits |
| cout | output | 1 | Carry out of bit 15 |
| blk_p | output | 1 | Block propagate for a higher lookahead level |
| blk_g | output | 1 | Block generate for a higher lookahead level |

## Verification
Two things happen in the same evaluation: the block-level propagate/generate pair settles, and the carry-in is resolved into the sum and carry-out through that pair. The bench provokes this overlap by holding the operands fixed and toggling only `cin`. It uses operands that make the block propagate, generate, or do neither. It then judges the result by three checks: `blk_p` and `blk_g` must stay stable across the toggle, `cout` must follow R6, and `sum` must match a 17-bit reference addition. Patterns that stress the carry chain are also applied in both operand orders. These include all-ones plus one, single-zero words plus one, single-one and adjacent-pair words added to all-ones, and pseudo-random words.

// File: rtl/cla_pkg.sv
package cla_pkg;

    typedef struct packed {
        logic prop;
        logic gen;
    } pg_pair_t;

    function automatic pg_pair_t make_pg(input logic x, input logic y);
        pg_pair_t r;
        r.prop = x ^ y;
        r.gen  = x & y;
        return r;
    endfunction

endpackage

// File: rtl/cla_bit_pg.sv
module cla_bit_pg #(
    parameter int BITS = 4
) (
    input  logic [BITS-1:0] x,
    input  logic [BITS-1:0] y,
    output logic [BITS-1:0] p,
    output logic [BITS-1:0] g
);
    import cla_pkg::*;

    for (genvar i = 0; i < BITS; i++) begin : g_bit
        pg_pair_t pr;
        assign pr   = make_pg(x[i], y[i]);
        assign p[i] = pr.prop;
        assign g[i] = pr.gen;
    end
endmodule

// File: rtl/cla_lookahead_unit.sv
module cla_lookahead_unit #(
    parameter int N = 4
) (
    input  logic [N-1:0] p,
    input  logic [N-1:0] g,
    input  logic         cin,
    output logic [N-1:0] cvec,
    output logic         cout,
    output logic         grp_p,
    output logic         grp_g
);
    logic [N:0] cv;
    logic       gv;

    // Flat sum-of-products for every carry: no carry feeds another.
    always_comb begin
        logic acc;
        cv = '0;
        for (int k = 0; k <= N; k++) begin
            acc = cin;
            for (int m = 0; m < k; m++) acc = acc & p[m];
            cv[k] = acc;
            for (int j = 0; j < k; j++) begin
                acc = g[j];
                for (int m = j + 1; m < k; m++) acc = acc & p[m];
                cv[k] = cv[k] | acc;
            end
        end
    end

    // Generate term taken with a zero carry-in.
    always_comb begin
        logic acc;
        gv = 1'b0;
        for (int j = 0; j < N; j++) begin
            acc = g[j];
            for (int m = j + 1; m < N; m++) acc = acc & p[m];
            gv = gv | acc;
        end
    end

    assign cvec  = cv[N-1:0];
    assign cout  = cv[N];
    assign grp_p = &p;
    assign grp_g = gv;

    // R6: carry out splits into generate plus propagated carry-in
    always_comb begin
        p_carry_split_r6: assert (cout == (grp_g | (grp_p & cin)))
            else $error("lookahead carry split mismatch");
    end
endmodule

// File: rtl/cla_group.sv
module cla_group #(
    parameter int BITS = 4
) (
    input  logic [BITS-1:0] x,
    input  logic [BITS-1:0] y,
    input  logic            cin,
    output logic [BITS-1:0] s,
    output logic            cout,
    output logic            gp,
    output logic            gg
);
    logic [BITS-1:0] p, g, c;

    cla_bit_pg #(.BITS(BITS)) u_pg (
        .x(x), .y(y), .p(p), .g(g)
    );

    cla_lookahead_unit #(.N(BITS)) u_la (
        .p(p), .g(g), .cin(cin),
        .cvec(c), .cout(cout), .grp_p(gp), .grp_g(gg)
    );

    assign s = p ^ c;

    // R5: a group never both propagates and generates
    always_comb begin
        p_grp_excl_r5: assert (!(gp && gg))
            else $error("group propagate and generate both high");
    end
endmodule

// File: rtl/cla_adder16.sv
module cla_adder16 #(
    parameter int GRP_BITS  = 4,
    parameter int GRP_COUNT = 4
) (
    input  logic [GRP_BITS*GRP_COUNT-1:0] a,
    input  logic [GRP_BITS*GRP_COUNT-1:0] b,
    input  logic                          cin,
    output logic [GRP_BITS*GRP_COUNT-1:0] sum,
    output logic                          cout,
    output logic                          blk_p,
    output logic                          blk_g
);
    localparam int W = GRP_BITS * GRP_COUNT;

    logic [GRP_COUNT-1:0] gp, gg, gc, gco;

    for (genvar i = 0; i < GRP_COUNT; i++) begin : g_grp
        cla_group #(.BITS(GRP_BITS)) u_grp (
            .x   (a[i*GRP_BITS +: GRP_BITS]),
            .y   (b[i*GRP_BITS +: GRP_BITS]),
            .cin (gc[i]),
            .s   (sum[i*GRP_BITS +: GRP_BITS]),
            .cout(gco[i]),
            .gp  (gp[i]),
            .gg  (gg[i])
        );
    end

    cla_lookahead_unit #(.N(GRP_COUNT)) u_top_la (
        .p(gp), .g(gg), .cin(cin),
        .cvec(gc), .cout(cout), .grp_p(blk_p), .grp_g(blk_g)
    );

    always_comb begin
        logic [W:0] ref_sum;
        ref_sum = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, cin};
        // R1, R2: sum and carry-out agree with a 17-bit reference
        p_sum_ref_r1: assert ({cout, sum} == ref_sum)
            else $error("sum mismatch");
        // R3: block propagate matches all bit positions differing
        p_blk_p_r3: assert (blk_p == (&(a ^ b)))
            else $error("block propagate mismatch");
        // R7: neither propagate nor generate means no carry out
        p_quiet_cout_r7: assert (blk_p || blk_g || !cout)
            else $error("carry out without propagate or generate");
        // R5: block flags exclusive
        p_blk_excl_r5: assert (!(blk_p && blk_g))
            else $error("block propagate and generate both high");
        // Second-level carry into top group agrees with lower group carry out
        p_grp_chain_r2: assert (gc[GRP_COUNT-1] == gco[GRP_COUNT-2])
            else $error("group carry mismatch");
    end
endmodule

// File: tb/tb_cla_adder16.sv
module tb_cla_adder16;
    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2 clk = ~clk;

    logic [15:0] a_i = '0, b_i = '0, sum_o;
    logic        cin_i = 1'b0, cout_o, bp_o, bg_o;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    cla_adder16 dut (
        .a(a_i), .b(b_i), .cin(cin_i),
        .sum(sum_o), .cout(cout_o), .blk_p(bp_o), .blk_g(bg_o)
    );

    task automatic chk(input bit ok, input string req,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic drive(input logic [15:0] x, input logic [15:0] y, input logic ci);
        @(posedge clk);
        a_i = x; b_i = y; cin_i = ci;
        @(negedge clk);
    endtask

    // Full check of one vector in both operand orders (R1..R8)
    task automatic apply(input logic [15:0] x, input logic [15:0] y, input logic ci);
        logic [16:0] full;
        logic [16:0] nocin;
        logic [18:0] first;
        full  = {1'b0, x} + {1'b0, y} + {16'b0, ci};
        nocin = {1'b0, x} + {1'b0, y};
        for (int ord = 0; ord < 2; ord++) begin
            if (ord == 0) drive(x, y, ci); else drive(y, x, ci);
            chk(sum_o == full[15:0], "R1 sum", sum_o, full[15:0]);
            chk(cout_o == full[16], "R2 cout", cout_o, full[16]);
            chk(bp_o == ((x ^ y) == 16'hFFFF), "R3 blk_p", bp_o, ((x ^ y) == 16'hFFFF));
            chk(bg_o == nocin[16], "R4 blk_g", bg_o, nocin[16]);
            chk(!(bp_o && bg_o), "R5 exclusive", {bp_o, bg_o}, 2'b00);
            chk(cout_o == (bg_o | (bp_o & ci)), "R6 cout split", cout_o, bg_o | (bp_o & ci));
            if (ord == 0) first = {cout_o, bp_o, bg_o, sum_o};
            else chk(first == {cout_o, bp_o, bg_o, sum_o}, "R8 commute",
                     {cout_o, bp_o, bg_o, sum_o}, first);
        end
    endtask

    task automatic t_reset_state();
        @(negedge clk);
        chk(sum_o == 16'h0 && !cout_o, "R1 reset-state sum", {cout_o, sum_o}, 0);
        chk(!bp_o && !bg_o, "R4 reset-state flags", {bp_o, bg_o}, 0);
    endtask

    task automatic t_all_ones_plus_one();
        drive(16'hFFFF, 16'h0001, 1'b0);
        chk(sum_o == 16'h0000 && cout_o, "R9 ones+1", {cout_o, sum_o}, 17'h10000);
        drive(16'h0001, 16'hFFFF, 1'b0);
        chk(sum_o == 16'h0000 && cout_o, "R9 1+ones", {cout_o, sum_o}, 17'h10000);
        apply(16'hFFFF, 16'h0001, 1'b0);
        apply(16'hFFFF, 16'h0000, 1'b1);
    endtask

    task automatic t_lone_zero();
        for (int k = 0; k < 16; k++) begin
            logic [15:0] w, e;
            w = ~(16'h1 << k);
            e = 16'hFFFF << k;
            drive(w, 16'h0001, 1'b0);
            chk(sum_o == e && !cout_o, "R10 lone zero", {cout_o, sum_o}, {1'b0, e});
            drive(16'h0001, w, 1'b0);
            chk(sum_o == e && !cout_o, "R10 lone zero swapped", {cout_o, sum_o}, {1'b0, e});
            apply(w, 16'h0001, 1'b0);
        end
    endtask

    task automatic t_lone_one_and_pair();
        for (int k = 0; k < 16; k++) begin
            apply(16'hFFFF, 16'h1 << k, 1'b0);
            apply(16'hFFFF, 16'h1 << k, 1'b1);
            if (k < 15) begin
                apply(16'hFFFF, 16'h3 << k, 1'b0);
                apply(16'h3 << k, 16'h3 << k, 1'b1);
            end
        end
    endtask

    // Operands fixed, cin toggled: flags stable, carry follows them (R4, R6, R7)
    task automatic t_cin_toggle();
        logic [15:0] xs [4] = '{16'h00FF, 16'hF0F0, 16'h8000, 16'h1234};
        logic [15:0] ys [4] = '{16'hFF00, 16'h1F10, 16'h8000, 16'h0101};
        for (int i = 0; i < 4; i++) begin
            logic pb, gb;
            drive(xs[i], ys[i], 1'b0);
            pb = bp_o; gb = bg_o;
            drive(xs[i], ys[i], 1'b1);
            chk(bp_o == pb && bg_o == gb, "R4 flags stable on cin", {bp_o, bg_o}, {pb, gb});
            chk(cout_o == (gb | pb), "R6 cout with cin=1", cout_o, gb | pb);
            if (!pb && !gb)
                chk(!cout_o, "R7 quiet cout", cout_o, 0);
        end
    endtask

    task automatic t_sweep();
        logic [31:0] lf = 32'hACE1_1234;
        for (int i = 0; i < 1500; i++) begin
            lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
            apply(lf[15:0], lf[31:16], lf[7]);
            if (i % 64 == 0) apply(lf[15:0], ~lf[15:0], lf[3]);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=1 expected=0");
        finish_run();
    end

    initial begin
        repeat (2) @(posedge clk);
        rst = 1'b0;
        t_reset_state();
        t_all_ones_plus_one();
        t_lone_zero();
        t_lone_one_and_pair();
        t_cin_toggle();
        t_sweep();
        finish_run();
    end
endmodule